// File: doc/BRIEF.md
# Embedded-to-Discrete Video Sync Converter

This block takes a 16-bit 4:2:2 YCbCr stream whose line and frame timing is carried inside the data as timing reference codes. It rebuilds that timing as separate horizontal sync, vertical sync, data-enable and field wires. A receiver that expects discrete-sync video can then take the stream without a per-format timing table.

A timing code is four words long. It is recognised on the luma byte (bits 15:8) only, as the preamble FF, 00, 00 followed by a status word that carries the field bit, the vertical-blanking bit and the start/end-of-line bit, plus four protection bits. Before the words reach the output they pass through a short shift register. This lets the block see a complete code before its first word leaves, so the sync wires change on the same output cycle as that first word. The chroma byte travels through the same delay untouched.

Top module: `sync_extract`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, every output is 0.
- R2: A 16-bit word sampled on a rising edge of clk appears unchanged on vid_o after the fourth rising edge that follows.
- R3: A timing code is the luma sequence FF, 00, 00 followed by a status word whose bit 7 is 1, bit 6 is F (field), bit 5 is V (vertical blanking) and bit 4 is H (0 = start of active line, 1 = end of active line). Bits 3..0 must equal V^H, F^H, F^V and F^V^H, from bit 3 down to bit 0.
- R4: de_o is 0 on the four output cycles of any code. After a valid start code with V=0, de_o is 1 from the first word after the code until the word before the next valid end code or valid start code with V=1.
- R5: On the output cycle that shows the first word of a valid end code, hsync_o goes to 1. It stays at 1 for HS_LEN consecutive cycles, and a new valid end code restarts the count.
- R6: From the output cycle of the first word of a valid code, vsync_o equals that code's V bit and field_o equals its F bit, until the next valid code.
- R7: A code whose preamble matches but whose status word has bit 7 at 0, or any protection bit wrong, raises err_o for exactly the output cycle of its first word. It leaves vsync_o, field_o, the de_o line state and hsync_o unchanged.
- R8: The chroma byte (bits 7:0) is never examined for codes. The sequence FF, 00, 00, status word on chroma alone changes no sync output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_i | input | 16 | Input video; luma in 15:8, chroma in 7:0, with embedded codes |
| vid_o | output | 16 | Video delayed to line up with the sync outputs |
| de_o | output | 1 | Active-pixel data enable |
| hsync_o | output | 1 | Horizontal sync pulse, HS_LEN cycles from each end code |
| vsync_o | output | 1 | Vertical blanking, last decoded V bit |
| field_o | output | 1 | Field, last decoded F bit |
| err_o | output | 1 | One-cycle flag for a code whose status word fails its checks |

## Verification
The assertions assume that the luma sequence FF, 00, 00 occurs only as the start of a timing code. They also assume that two codes are at least four words apart, so an error flag can never be followed straight away by another. The stimulus keeps every pixel luma value between 0x10 and 0xF0 and separates codes by at least one pixel word. The only FF/00 runs outside the codes are placed on the chroma lane, to show that chroma is ignored.

// File: rtl/sync_extract.sv
module sync_extract #(
  parameter int HS_LEN = 8,
  parameter int HS_W   = $clog2(HS_LEN + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] vid_i,
  output logic [15:0] vid_o,
  output logic        de_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        field_o,
  output logic        err_o
);

  logic [15:0] s0, s1, s2, s3;
  logic [1:0]  code_left;
  logic        line_on;
  logic [HS_W-1:0] hs_cnt;

  wire [7:0] xyz = s0[15:8];
  wire xf = xyz[6];
  wire xv = xyz[5];
  wire xh = xyz[4];
  wire pre  = (s3[15:8] == 8'hFF) && (s2[15:8] == 8'h00) && (s1[15:8] == 8'h00);
  wire ok   = xyz[7] && (xyz[3:0] == {xv ^ xh, xf ^ xh, xf ^ xv, xf ^ xv ^ xh});
  wire good = pre && ok;

  assign hsync_o = (hs_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0 <= '0; s1 <= '0; s2 <= '0; s3 <= '0;
      vid_o <= '0;
      de_o <= 1'b0;
      vsync_o <= 1'b0;
      field_o <= 1'b0;
      err_o <= 1'b0;
      code_left <= '0;
      line_on <= 1'b0;
      hs_cnt <= '0;
    end else begin
      s0 <= vid_i;
      s1 <= s0;
      s2 <= s1;
      s3 <= s2;
      vid_o <= s3;
      err_o <= pre && !ok;
      de_o <= !pre && (code_left == 2'd0) && line_on;

      if (pre) code_left <= 2'd3;
      else if (code_left != 2'd0) code_left <= code_left - 2'd1;

      if (good) begin
        vsync_o <= xv;
        field_o <= xf;
        line_on <= !xh && !xv;
      end

      if (good && xh) hs_cnt <= HS_W'(HS_LEN);
      else if (hs_cnt != '0) hs_cnt <= hs_cnt - 1'b1;
    end
  end

  p_de_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_left != 2'd0) |-> !de_o);

  p_hs_eav_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (good && xh) |=> hsync_o);

  p_vs_nodata_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_o |-> !de_o);

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(vsync_o) && $stable(field_o)));

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

endmodule

// File: tb/tb_sync_extract.sv
`timescale 1ns/1ps
module tb_sync_extract;
  localparam int HS = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] vid_i = '0;
  logic [15:0] vid_o;
  logic de_o, hsync_o, vsync_o, field_o, err_o;

  sync_extract #(.HS_LEN(HS)) dut (
    .clk(clk), .rst_n(rst_n), .vid_i(vid_i), .vid_o(vid_o),
    .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .field_o(field_o), .err_o(err_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [15:0] d;
    logic de, hs, vs, fd, er;
    int stamp;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit m_f = 0, m_v = 0, m_line = 0;
  int m_hs = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic slot(input logic [15:0] w, input bit de, input bit er, input string req);
    exp_t it;
    @(negedge clk);
    vid_i = w;
    it.d = w; it.de = de; it.er = er; it.req = req;
    it.hs = (m_hs != 0);
    if (m_hs != 0) m_hs--;
    it.vs = m_v; it.fd = m_f;
    it.stamp = cyc;
    q.push_back(it);
  endtask

  // mode 0 good, 1 protection bit flipped, 2 bit 7 cleared
  task automatic send_code(input bit f, input bit v, input bit h, input int mode);
    logic [7:0] x;
    bit ok;
    string rq;
    x = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    if (mode == 1) x = x ^ 8'h01;
    if (mode == 2) x[7] = 1'b0;
    ok = (mode == 0);
    if (ok) begin
      m_f = f; m_v = v;
      if (h) m_hs = HS;
      m_line = !h && !v;
    end
    rq = !ok ? "R7" : (h ? "R5" : "R6");
    slot({8'hFF, 8'hFF}, 1'b0, !ok, rq);
    slot(16'h0000, 1'b0, 1'b0, "R4");
    slot(16'h0000, 1'b0, 1'b0, "R3");
    slot({x, x}, 1'b0, 1'b0, "R4");
  endtask

  task automatic pixels(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++)
      slot({base + 8'(i), 8'h80 ^ 8'(i)}, m_line, 1'b0, "R2");
  endtask

  task automatic chroma_trap();
    slot({8'h40, 8'hFF}, m_line, 1'b0, "R8");
    slot({8'h41, 8'h00}, m_line, 1'b0, "R8");
    slot({8'h42, 8'h00}, m_line, 1'b0, "R8");
    slot({8'h43, 8'hB6}, m_line, 1'b0, "R8");
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].stamp + 5 == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({vid_o, de_o, hsync_o, vsync_o, field_o, err_o} !==
          {e.d, e.de, e.hs, e.vs, e.fd, e.er}) begin
        fails++;
        $display("FAIL %s cyc=%0d actual d=%h de=%b hs=%b vs=%b f=%b err=%b expected d=%h de=%b hs=%b vs=%b f=%b err=%b",
          e.req, cyc, vid_o, de_o, hsync_o, vsync_o, field_o, err_o,
          e.d, e.de, e.hs, e.vs, e.fd, e.er);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({vid_o, de_o, hsync_o, vsync_o, field_o, err_o} !== 21'd0) begin
      fails++;
      $display("FAIL R1 actual=%h expected=0", {vid_o, de_o, hsync_o, vsync_o, field_o, err_o});
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if ({vid_o, de_o, hsync_o, vsync_o, field_o, err_o} !== 21'd0) begin
      fails++;
      $display("FAIL R1 after release actual=%h expected=0", {vid_o, de_o, hsync_o, vsync_o, field_o, err_o});
    end

    pixels(6, 8'h10);
    send_code(0, 1, 1, 0);  pixels(10, 8'h20);
    send_code(0, 1, 0, 0);  pixels(16, 8'h30);
    send_code(0, 0, 1, 0);  pixels(6, 8'h50);
    send_code(0, 0, 0, 0);  pixels(16, 8'h60);
    send_code(0, 0, 1, 0);  pixels(4, 8'h70);
    send_code(0, 0, 0, 0);  chroma_trap(); pixels(8, 8'h80);
    send_code(0, 0, 1, 0);  pixels(12, 8'h90);
    send_code(1, 1, 1, 1);  pixels(6, 8'hA0);
    send_code(1, 0, 0, 2);  pixels(6, 8'hB0);
    send_code(1, 0, 0, 0);  pixels(12, 8'hC0);
    send_code(1, 0, 1, 1);  pixels(6, 8'hD0);
    send_code(1, 0, 1, 0);  pixels(3, 8'hE0);
    send_code(1, 1, 0, 0);  pixels(12, 8'hE0);
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule